// File: doc/BRIEF.md
# Bundle Template Decoder and Group Issue Stage

This stage sits between instruction fetch and the execution units of a wide in-order core that relies on compiler-scheduled parallelism. Each cycle it can take a pair of 128-bit instruction bundles. Each bundle carries a 5-bit template and three 41-bit instruction slots. The template tells the stage which kind of execution unit each slot needs and where the compiler placed stop markers. Stop markers separate instruction groups, and a group may run across the two bundles of a pair.

The stage loads an accepted pair into a six-entry window. It then issues one group per cycle, in program order, onto six lanes that fill from lane 0. When a stop falls inside the window, the slots after it stay in the window and issue first in the next cycle. Fetch is held off until the window drains. Every issued slot is qualified by a one-bit predicate register, named by the slot's low six bits, and read from a 64-entry predicate file. A slot whose predicate is false keeps its lane with its valid bit low.

Top module: `bundle_issue`

## Requirements
- R1: A bundle carries its template in bits 4:0 and its slots in bits 45:5 (slot 0), 86:46 (slot 1) and 127:87 (slot 2). Each issued slot appears unchanged on its lane of `lane_insn`, at bits 41*k+40:41*k for lane k. The slot's predicate number is its bits 5:0.
- R2: The unit kind of lane k is on `lane_unit[2k+1:2k]`, coded memory=0, integer=1, float=2, branch=3. Template codes 0/1 give M,I,I; 2/3 give M,I,I; 4/5 M,M,I; 6/7 M,F,I; 8/9 M,M,F; 10/11 M,I,B; 12/13 M,B,B; 14/15 B,B,B; 16/17 M,M,B; 18/19 M,F,B (slots 0,1,2).
- R3: Bit 0 of a legal template code places a stop after slot 2. Codes 2 and 3 also place a stop after slot 1. One cycle issues the oldest window slots up to and including the first slot that carries a stop, or all of them if none does. They go onto lanes 0 upward in program order, bundle 0 before bundle 1, and `lane_used` marks the occupied lanes.
- R4: Slots left behind a stop issue first in the next cycle. `in_ready` is low in any cycle in which slots will remain in the window after this cycle's issue.
- R5: When `in_ready` is high and `in_valid` is high, the pair is taken at that clock edge and its first group is on the lanes in the following cycle. A stream of stop-free pairs is therefore accepted on every cycle.
- R6: Template codes 20 to 31 are illegal. For an accepted pair, `bad_tmpl[b]` is high during the cycle after acceptance if bundle b was illegal. None of that bundle's slots ever issue.
- R7: `lane_valid[k]` is high only when lane k is used and the predicate register named by its slot reads true. A squashed slot still occupies its lane, so later slots keep their lanes.
- R8: A predicate write (`pw_en`, `pw_idx`, `pw_val`) is seen by issue from the cycle after the write edge. Register 0 always reads true, and writes to it are ignored.
- R9: After reset the window is empty, all lane outputs and `bad_tmpl` are zero, `in_ready` is high, and predicate registers 1 to 63 read false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A bundle pair is offered |
| in_bundle0 | input | 128 | Older bundle of the pair |
| in_bundle1 | input | 128 | Younger bundle of the pair |
| in_ready | output | 1 | The pair is taken at this edge if offered |
| pw_en | input | 1 | Predicate write enable |
| pw_idx | input | 6 | Predicate register number |
| pw_val | input | 1 | Predicate value to write |
| lane_used | output | 6 | Lane holds a slot of the current group |
| lane_valid | output | 6 | Lane holds a slot whose predicate is true |
| lane_unit | output | 12 | Unit kind per lane, 2 bits each |
| lane_insn | output | 246 | Raw slot per lane, 41 bits each |
| bad_tmpl | output | 2 | Illegal template flag per bundle of the last accepted pair |

## Verification
The bench pairs every one of the 32 template codes for the older bundle with every code for the younger one. This covers stops that split a group mid-bundle, at the bundle boundary and at the end of the pair. A design that lost track of the window head would reissue slots or drop the tail after a mid-bundle stop. One that ignored a stop would merge two groups onto the lanes. Illegal codes in either bundle, or in both, check that the other bundle still issues in order and is not shifted into the wrong lanes. Predicate writes run during the sweep, so a read that sees a write a cycle early or late shows up as a flipped valid bit. Writes of false to register 0 catch a file that lets it be written.

// File: rtl/bundle_issue_pkg.sv
// Shared constants and types for the bundle issue stage.
// Assumes three slots per bundle and a fixed bundle layout (template low).
package bundle_issue_pkg;
    localparam int TMPL_W   = 5;
    localparam int SLOT_W   = 41;
    localparam int SLOTS    = 3;
    localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W;
    localparam int QP_W     = 6;

    typedef enum logic [1:0] {
        UNIT_MEM = 2'd0,
        UNIT_INT = 2'd1,
        UNIT_FP  = 2'd2,
        UNIT_BR  = 2'd3
    } unit_e;

    typedef struct packed {
        logic [SLOT_W-1:0] insn;
        unit_e             unit;
        logic              stop;
    } slot_t;
endpackage

// File: rtl/tmpl_decoder.sv
// Splits one bundle into its three slots and decodes the template into a
// unit kind and a stop-after flag per slot. Purely combinational.
// Assumes template codes 20..31 are unassigned and reports them as illegal.
module tmpl_decoder
    import bundle_issue_pkg::*;
(
    input  logic [BUNDLE_W-1:0] bundle_i,
    output slot_t [SLOTS-1:0]   slots_o,
    output logic                illegal_o
);
    logic [TMPL_W-1:0] tmpl;
    logic [TMPL_W-2:0] kind;
    unit_e             u [SLOTS];
    logic              mid_stop;

    assign tmpl = bundle_i[TMPL_W-1:0];
    assign kind = tmpl[TMPL_W-1:1];

    // Map the template family to unit kinds and the mid-bundle stop.
    always_comb begin
        illegal_o = 1'b0;
        mid_stop  = 1'b0;
        u[0] = UNIT_MEM; u[1] = UNIT_INT; u[2] = UNIT_INT;
        case (kind)
            4'd0: ;
            4'd1: mid_stop = 1'b1;
            4'd2: u[1] = UNIT_MEM;
            4'd3: u[1] = UNIT_FP;
            4'd4: begin u[1] = UNIT_MEM; u[2] = UNIT_FP; end
            4'd5: u[2] = UNIT_BR;
            4'd6: begin u[1] = UNIT_BR;  u[2] = UNIT_BR; end
            4'd7: begin u[0] = UNIT_BR; u[1] = UNIT_BR; u[2] = UNIT_BR; end
            4'd8: begin u[1] = UNIT_MEM; u[2] = UNIT_BR; end
            4'd9: begin u[1] = UNIT_FP;  u[2] = UNIT_BR; end
            default: illegal_o = 1'b1;
        endcase
    end

    // Slice each slot and attach its unit kind and stop flag.
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        assign slots_o[j].insn = bundle_i[TMPL_W + j*SLOT_W +: SLOT_W];
        assign slots_o[j].unit = u[j];
        if (j == SLOTS - 1) begin : g_last
            assign slots_o[j].stop = tmpl[0];
        end else if (j == 1) begin : g_mid
            assign slots_o[j].stop = mid_stop;
        end else begin : g_none
            assign slots_o[j].stop = 1'b0;
        end
    end
endmodule

// File: rtl/pred_file.sv
// One-bit predicate register file with one write port and one read port
// per issue lane. Register 0 is hard-wired true and ignores writes.
// Reads are combinational from the stored state; writes land at the edge.
module pred_file #(
    parameter int NREGS = 64,
    parameter int LANES = 6,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [AW-1:0]       waddr_i,
    input  logic                wdata_i,
    input  logic [LANES*AW-1:0] raddr_i,
    output logic [LANES-1:0]    rdata_o
);
    logic [NREGS-1:0] bits_q;

    // Store writes to registers other than 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we_i && (waddr_i != '0)) begin
            bits_q[waddr_i] <= wdata_i;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra = raddr_i[k*AW +: AW];
        // Read one predicate, forcing register 0 to true.
        assign rdata_o[k] = (ra == '0) ? 1'b1 : bits_q[ra];
    end
endmodule

// File: rtl/group_select.sv
// Picks the oldest instruction group out of the live window entries and
// packs it onto lanes 0 upward in program order. Combinational.
// Assumes window position 0 is the oldest slot.
module group_select
    import bundle_issue_pkg::*;
#(
    parameter int POS = 6
) (
    input  logic [POS-1:0]  live_i,
    input  slot_t [POS-1:0] slots_i,
    output logic [POS-1:0]  take_o,
    output logic [POS-1:0]  used_o,
    output slot_t [POS-1:0] lanes_o
);
    // Walk the window, closing the group after the first live stop.
    always_comb begin
        logic open;
        int   cnt;
        open    = 1'b1;
        cnt     = 0;
        take_o  = '0;
        used_o  = '0;
        lanes_o = '0;
        for (int p = 0; p < POS; p++) begin
            if (live_i[p] && open) begin
                take_o[p]    = 1'b1;
                lanes_o[cnt] = slots_i[p];
                used_o[cnt]  = 1'b1;
                cnt          = cnt + 1;
                if (slots_i[p].stop) open = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bundle_issue.sv
// Bundle pair intake, six-entry issue window and predicate-qualified lanes.
// A pair is taken only when the window will be empty after this cycle's
// issue; each cycle issues one stop-delimited group from the window head.
module bundle_issue
    import bundle_issue_pkg::*;
#(
    parameter int NBUNDLE = 2,
    parameter int NPRED   = 64,
    localparam int POS    = NBUNDLE * SLOTS,
    localparam int PAW    = $clog2(NPRED)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [BUNDLE_W-1:0]        in_bundle0,
    input  logic [BUNDLE_W-1:0]        in_bundle1,
    output logic                       in_ready,
    input  logic                       pw_en,
    input  logic [PAW-1:0]             pw_idx,
    input  logic                       pw_val,
    output logic [POS-1:0]             lane_used,
    output logic [POS-1:0]             lane_valid,
    output logic [POS*2-1:0]           lane_unit,
    output logic [POS*SLOT_W-1:0]      lane_insn,
    output logic [NBUNDLE-1:0]         bad_tmpl
);
    logic [BUNDLE_W-1:0] bundles [NBUNDLE];
    slot_t [POS-1:0]     dec_slots;
    logic [NBUNDLE-1:0]  dec_bad;
    logic [POS-1:0]      dec_live;

    slot_t [POS-1:0]     win_slot_q;
    logic [POS-1:0]      win_live_q;
    logic [NBUNDLE-1:0]  bad_q;

    logic [POS-1:0]      take;
    logic [POS-1:0]      remain;
    slot_t [POS-1:0]     lanes;
    logic [POS*PAW-1:0]  qp_flat;
    logic [POS-1:0]      pred_rd;
    logic                accept;

    assign bundles[0] = in_bundle0;
    assign bundles[1] = in_bundle1;

    for (genvar b = 0; b < NBUNDLE; b++) begin : g_dec
        tmpl_decoder u_dec (
            .bundle_i  (bundles[b]),
            .slots_o   (dec_slots[b*SLOTS +: SLOTS]),
            .illegal_o (dec_bad[b])
        );
        // Slots of an illegal bundle never enter the window as live.
        assign dec_live[b*SLOTS +: SLOTS] = {SLOTS{~dec_bad[b]}};
    end

    group_select #(.POS(POS)) u_grp (
        .live_i  (win_live_q),
        .slots_i (win_slot_q),
        .take_o  (take),
        .used_o  (lane_used),
        .lanes_o (lanes)
    );

    assign remain   = win_live_q & ~take;
    assign in_ready = ~|remain;
    assign accept   = in_valid && in_ready;

    // Load a new pair, or retire the issued group from the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_slot_q <= '0;
            win_live_q <= '0;
            bad_q      <= '0;
        end else if (accept) begin
            win_slot_q <= dec_slots;
            win_live_q <= dec_live;
            bad_q      <= dec_bad;
        end else begin
            win_live_q <= remain;
            bad_q      <= '0;
        end
    end

    pred_file #(.NREGS(NPRED), .LANES(POS)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (pw_en),
        .waddr_i (pw_idx),
        .wdata_i (pw_val),
        .raddr_i (qp_flat),
        .rdata_o (pred_rd)
    );

    for (genvar k = 0; k < POS; k++) begin : g_lane
        assign qp_flat[k*PAW +: PAW]     = lanes[k].insn[PAW-1:0];
        assign lane_unit[k*2 +: 2]       = lanes[k].unit;
        assign lane_insn[k*SLOT_W +: SLOT_W] = lanes[k].insn;
        assign lane_valid[k]             = lane_used[k] & pred_rd[k];

        AST_P0_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_used[k] && lanes[k].insn[PAW-1:0] == '0) |-> lane_valid[k]); // R8
    end

    assign bad_tmpl = bad_q;

    AST_USED_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_used & (lane_used + 1'b1)) == '0); // R3
    AST_SQUASH_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid & ~lane_used) == '0); // R7
    AST_HELD_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> lane_used[0]); // R4
    AST_ILLEGAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (&bad_tmpl) |-> (lane_used == '0)); // R6
endmodule

// File: tb/bundle_issue_tb_top.sv
// Self-checking bench: sweeps all template pairs against a model built
// from the requirements, with predicate writes running alongside.
module bundle_issue_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_bundle0 = '0;
    logic [127:0] in_bundle1 = '0;
    logic         in_ready;
    logic         pw_en = 1'b0;
    logic [5:0]   pw_idx = '0;
    logic         pw_val = 1'b0;
    logic [5:0]   lane_used;
    logic [5:0]   lane_valid;
    logic [11:0]  lane_unit;
    logic [245:0] lane_insn;
    logic [1:0]   bad_tmpl;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int pair_no = 0;

    // model state
    logic [40:0] m_insn [6];
    logic [1:0]  m_unit [6];
    logic        m_stop [6];
    logic [5:0]  m_live;
    logic [1:0]  m_bad;
    logic        m_pred [64];

    bundle_issue dut_i (.*);

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h (pair %0d)", req, act, exp, pair_no);
        end
    endtask

    // Unit kinds per R2, coded M=0 I=1 F=2 B=3.
    function automatic logic [1:0] unit_of(input int code, input int j);
        string s;
        case (code / 2)
            0, 1: s = "MII";
            2: s = "MMI";
            3: s = "MFI";
            4: s = "MMF";
            5: s = "MIB";
            6: s = "MBB";
            7: s = "BBB";
            8: s = "MMB";
            default: s = "MFB";
        endcase
        case (s[j])
            "M": return 2'd0;
            "I": return 2'd1;
            "F": return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [40:0] mk_insn(input int n, input int pos);
        logic [5:0] qp;
        qp = 6'((n * 13 + pos * 7) % 64);
        return {23'(n), 3'(pos), 9'h0A5, qp};
    endfunction

    function automatic logic [127:0] mk_bundle(input int n, input int b, input int code);
        return {mk_insn(n, 3*b+2), mk_insn(n, 3*b+1), mk_insn(n, 3*b), 5'(code)};
    endfunction

    // Load the model window from a pair, per R1, R2, R3, R6.
    task automatic model_load(input logic [127:0] b0, input logic [127:0] b1);
        for (int b = 0; b < 2; b++) begin
            logic [127:0] bb;
            int code;
            bb = (b == 0) ? b0 : b1;
            code = int'(bb[4:0]);
            m_bad[b] = (code >= 20);
            for (int j = 0; j < 3; j++) begin
                m_insn[3*b+j] = bb[5 + 41*j +: 41];
                m_unit[3*b+j] = unit_of(code, j);
                m_stop[3*b+j] = (j == 2) ? bb[0] : ((j == 1) && (code == 2 || code == 3));
                m_live[3*b+j] = (code < 20);
            end
        end
    endtask

    // One cycle: drive inputs, compare outputs with the model, advance.
    task automatic step(input logic v, input logic [127:0] b0, input logic [127:0] b1,
                        input logic we, input logic [5:0] wi, input logic wv,
                        output logic acc);
        logic [5:0] e_used, e_valid, take;
        logic [11:0] e_unit;
        logic [245:0] e_insn;
        logic open, e_ready;
        int cnt;
        in_valid = v; in_bundle0 = b0; in_bundle1 = b1;
        pw_en = we; pw_idx = wi; pw_val = wv;
        #1;
        open = 1'b1; cnt = 0; e_used = '0; e_valid = '0; e_unit = '0; e_insn = '0; take = '0;
        for (int p = 0; p < 6; p++) begin
            if (m_live[p] && open) begin
                take[p] = 1'b1;
                e_used[cnt] = 1'b1;
                e_valid[cnt] = m_pred[m_insn[p][5:0]];
                e_unit[2*cnt +: 2] = m_unit[p];
                e_insn[41*cnt +: 41] = m_insn[p];
                cnt = cnt + 1;
                if (m_stop[p]) open = 1'b0;
            end
        end
        e_ready = ((m_live & ~take) == '0);
        chk(lane_used == e_used, "R3 lane_used", 256'(lane_used), 256'(e_used));
        chk(lane_insn == e_insn, "R1 lane_insn", 256'(lane_insn), 256'(e_insn));
        chk(lane_unit == e_unit, "R2 lane_unit", 256'(lane_unit), 256'(e_unit));
        chk(lane_valid == e_valid, "R7 R8 lane_valid", 256'(lane_valid), 256'(e_valid));
        chk(in_ready == e_ready, "R4 in_ready", 256'(in_ready), 256'(e_ready));
        chk(bad_tmpl == m_bad, "R6 bad_tmpl", 256'(bad_tmpl), 256'(m_bad));
        acc = v && e_ready;
        @(posedge clk);
        if (acc) model_load(b0, b1);
        else begin
            m_live = m_live & ~take;
            m_bad = '0;
        end
        if (we && wi != 6'd0) m_pred[wi] = wv;
        @(negedge clk);
    endtask

    initial begin
        logic acc;
        int run;
        m_live = '0; m_bad = '0;
        for (int i = 0; i < 64; i++) m_pred[i] = (i == 0);
        for (int i = 0; i < 6; i++) begin m_insn[i] = '0; m_unit[i] = '0; m_stop[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(in_ready === 1'b1, "R9 in_ready", 256'(in_ready), 256'(1));
        chk(lane_used === '0 && lane_valid === '0, "R9 lanes", 256'({lane_used, lane_valid}), 256'(0));
        chk(lane_insn === '0 && lane_unit === '0, "R9 lane data", 256'(lane_insn), 256'(0));
        chk(bad_tmpl === '0, "R9 bad_tmpl", 256'(bad_tmpl), 256'(0));
        // R9: predicates read false after reset (only qp 0 lanes valid).
        pair_no = 1;
        do step(1, mk_bundle(1, 0, 0), mk_bundle(1, 1, 1), 0, 0, 0, acc); while (!acc);
        repeat (2) step(0, '0, '0, 0, 0, 0, acc);
        // R8: load predicate pattern A, including an ignored write to register 0.
        for (int i = 0; i < 64; i++) step(0, '0, '0, 1, 6'(i), (i % 3) != 1 && i != 0, acc);
        // Full template sweep, R1 R2 R3 R4 R6 R7; later half writes preds in flight (R8).
        for (int t0 = 0; t0 < 32; t0++) begin
            for (int t1 = 0; t1 < 32; t1++) begin
                pair_no = pair_no + 1;
                do begin
                    if (t0 >= 16) step(1, mk_bundle(pair_no, 0, t0), mk_bundle(pair_no, 1, t1),
                                       1, 6'((pair_no * 11) % 64), pair_no[1], acc);
                    else step(1, mk_bundle(pair_no, 0, t0), mk_bundle(pair_no, 1, t1),
                              0, 0, 0, acc);
                end while (!acc);
            end
        end
        repeat (6) step(0, '0, '0, 0, 0, 0, acc);
        // R5: stop-free pairs accepted on consecutive cycles.
        run = 0;
        for (int i = 0; i < 8; i++) begin
            pair_no = pair_no + 1;
            step(1, mk_bundle(pair_no, 0, 0), mk_bundle(pair_no, 1, 10), 0, 0, 0, acc);
            if (acc) run = run + 1;
        end
        chk(run == 8, "R5 back-to-back accepts", 256'(run), 256'(8));
        repeat (3) step(0, '0, '0, 0, 0, 0, acc);
        finish_run();
    end
endmodule